// File: doc/BRIEF.md
# Programmable Wait Timeout Counter

This block guards a wait inside a card host controller: after a command or a data phase has been issued, it counts card-clock cycles while the controller waits for the card to act (a data start bit, a completion signal). If the card acts in time, the wait ends quietly. If it does not, the block raises an error flag that stays set until software acknowledges it.

The allowed wait is set by a 7-bit configuration word. A 4-bit cycle count is scaled by one of eight fixed multipliers, so one small field covers waits from a single card clock to more than fifteen million. Counting advances only on cycles where the card-clock enable pulse is high, so the same block works at any card clock ratio. The same block can be instantiated once for a data wait and once for a completion-signal wait. The controller that owns it decides which status bit the error drives.

Top module: `timeout_watch`

## Requirements
- R1: After reset, `busy_o` and `err_o` are both low.
- R2: `cfg_i[3:0]` holds the cycle count N and `cfg_i[6:4]` holds the multiplier code. Codes 0 to 7 select the factors 1, 16, 128, 256, 1024, 4096, 65536 and 1048576. The wait limit is N times the selected factor, counted in enabled clocks.
- R3: Counting advances only on clocks where `tick_i` is high. A wait with `tick_i` held low never expires.
- R4: The clock edge that samples the limit-th `tick_i` since the start sets `err_o` and clears `busy_o`. Both changes are visible after that same edge. After limit minus one ticks, `busy_o` is still high and `err_o` is still low.
- R5: With N equal to 0, the wait expires on the first enabled clock after the start, whatever the multiplier code.
- R6: `event_i` during a wait clears `busy_o` and leaves `err_o` low. If `event_i` arrives in the same cycle as the final tick, it wins and no error is raised.
- R7: `start_i` loads the limit from `cfg_i` and sets `busy_o` on the next edge. A start during a wait restarts the count from zero. A start takes priority over `event_i` and `tick_i` in the same cycle.
- R8: `err_o` stays high until `err_clr_i` is pulsed. A new start does not clear it. An expiry in the same cycle as `err_clr_i` leaves it set.
- R9: The configuration is sampled only at the start. Changing `cfg_i` during a wait does not change that wait's limit.
- R10: While idle, `event_i` and `tick_i` have no effect: `busy_o` stays low and `err_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 7 | Limit configuration: cycle count [3:0], multiplier code [6:4] |
| start_i | input | 1 | Begin (or restart) a wait |
| event_i | input | 1 | Expected event arrived; ends the wait without an error |
| tick_i | input | 1 | Card-clock enable pulse; one count per high cycle |
| err_clr_i | input | 1 | Clears the sticky error flag |
| busy_o | output | 1 | A wait is in progress |
| err_o | output | 1 | Sticky timeout error |

## Verification
Every result is registered, so a stimulus presented before a rising edge shows at the outputs just after that edge. `busy_o` rises one edge after `start_i`. `err_o` rises, and `busy_o` falls, on the edge that samples the limit-th tick. The bench drives inputs on falling edges and holds them for exactly one rising edge. It samples outputs on the following falling edge. For each limit it checks after limit minus one ticks, where the wait must still be running, and again after the final tick, where it must have expired. This pins the expiry to a single edge and catches an off-by-one in either direction.

// File: rtl/timeout_watch.sv
module timeout_watch #(
  parameter int CYC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CYC_W+2:0] cfg_i,
  input  logic             start_i,
  input  logic             event_i,
  input  logic             tick_i,
  input  logic             err_clr_i,
  output logic             busy_o,
  output logic             err_o
);
  localparam int MAX_SHIFT = 20;
  localparam int CNT_W     = CYC_W + MAX_SHIFT;

  function automatic logic [4:0] shift_of(input logic [2:0] code);
    case (code)
      3'd0:    shift_of = 5'd0;
      3'd1:    shift_of = 5'd4;
      3'd2:    shift_of = 5'd7;
      3'd3:    shift_of = 5'd8;
      3'd4:    shift_of = 5'd10;
      3'd5:    shift_of = 5'd12;
      3'd6:    shift_of = 5'd16;
      default: shift_of = 5'd20;
    endcase
  endfunction

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] load_val;
  logic             busy_q, err_q;
  logic             expire;

  assign load_val = CNT_W'(cfg_i[CYC_W-1:0]) << shift_of(cfg_i[CYC_W+2:CYC_W]);
  assign expire   = busy_q && !start_i && !event_i && tick_i && (rem_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= load_val;
      busy_q <= 1'b1;
    end else if (busy_q && event_i) begin
      busy_q <= 1'b0;
    end else if (busy_q && tick_i) begin
      if (rem_q <= CNT_W'(1)) busy_q <= 1'b0;
      else                    rem_q  <= rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (expire)    err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;

  // R8
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(err_clr_i));

  // R4
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(busy_o && tick_i && !start_i && !event_i));

  // R7
  start_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  // R6
  event_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && event_i && !start_i) |=> !busy_o);

  // R3
  no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !start_i && !event_i) |=> (busy_o && $stable(rem_q)));

  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);
endmodule

// File: tb/timeout_watch_tb_top.sv
module timeout_watch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cfg = '0;
  logic       st = 0, ev = 0, tk = 0, clr = 0;
  logic       busy, err;
  int         n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  timeout_watch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .start_i(st), .event_i(ev),
    .tick_i(tk), .err_clr_i(clr), .busy_o(busy), .err_o(err)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic e, input logic t, input logic c);
    st = s; ev = e; tk = t; clr = c;
    @(negedge clk);
    st = 0; ev = 0; tk = 0; clr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 0);
  endtask

  task automatic begin_wait(input int code, input int n);
    cfg = {3'(code), 4'(n)};
    cyc(1, 0, 0, 0);
  endtask

  task automatic clear_err;
    cyc(0, 0, 0, 1);
  endtask

  task automatic t_reset;
    chk("R1", "busy after reset", busy, 1'b0);
    chk("R1", "err after reset", err, 1'b0);
  endtask

  task automatic t_factor(input int code, input int n, input int limit);
    begin_wait(code, n);
    chk("R7", "busy after start", busy, 1'b1);
    ticks(limit - 1);
    chk("R2", "busy one tick before limit", busy, 1'b1);
    chk("R4", "err one tick before limit", err, 1'b0);
    ticks(1);
    chk("R2", "err at limit", err, 1'b1);
    chk("R4", "busy at limit", busy, 1'b0);
    clear_err();
    chk("R8", "err after clear", err, 1'b0);
  endtask

  task automatic t_code7;
    begin_wait(7, 1);
    ticks(3000);
    chk("R2", "code 7 still busy after 3000 ticks", busy, 1'b1);
    chk("R2", "code 7 no err after 3000 ticks", err, 1'b0);
    cyc(0, 1, 0, 0);
    chk("R6", "event ends code 7 wait", busy, 1'b0);
    chk("R6", "event leaves err low", err, 1'b0);
  endtask

  task automatic t_zero;
    begin_wait(5, 0);
    repeat (4) cyc(0, 0, 0, 0);
    chk("R3", "zero limit waits for tick", busy, 1'b1);
    ticks(1);
    chk("R5", "zero limit err on first tick", err, 1'b1);
    chk("R5", "zero limit busy on first tick", busy, 1'b0);
    clear_err();
  endtask

  task automatic t_gaps;
    begin_wait(0, 3);
    cyc(0, 0, 1, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 0); repeat (10) cyc(0, 0, 0, 0);
    chk("R3", "no expiry without ticks", busy, 1'b1);
    chk("R3", "no err without ticks", err, 1'b0);
    cyc(0, 0, 1, 0);
    chk("R3", "expiry on third tick", err, 1'b1);
    clear_err();
  endtask

  task automatic t_event;
    begin_wait(0, 4);
    ticks(2);
    cyc(0, 1, 0, 0);
    chk("R6", "event clears busy", busy, 1'b0);
    ticks(5);
    chk("R6", "no err after event", err, 1'b0);
    begin_wait(0, 2);
    ticks(1);
    cyc(0, 1, 1, 0);
    chk("R6", "event wins final tick: err", err, 1'b0);
    chk("R6", "event wins final tick: busy", busy, 1'b0);
  endtask

  task automatic t_restart;
    begin_wait(0, 4);
    ticks(2);
    cfg = {3'd0, 4'd3};
    cyc(1, 0, 1, 0);
    ticks(2);
    chk("R7", "restart counts from zero", busy, 1'b1);
    chk("R7", "no err before new limit", err, 1'b0);
    ticks(1);
    chk("R7", "expiry at new limit", err, 1'b1);
    clear_err();
    begin_wait(0, 1);
    cyc(1, 1, 0, 0);
    chk("R7", "start beats event", busy, 1'b1);
    cyc(0, 1, 0, 0);
  endtask

  task automatic t_sticky;
    begin_wait(0, 1);
    ticks(1);
    repeat (10) cyc(0, 0, 0, 0);
    chk("R8", "err held while idle", err, 1'b1);
    begin_wait(0, 2);
    chk("R8", "start keeps err", err, 1'b1);
    ticks(1);
    cyc(0, 0, 1, 1);
    chk("R8", "expiry beats clear", err, 1'b1);
    clear_err();
    chk("R8", "clear drops err", err, 1'b0);
  endtask

  task automatic t_cfg_change;
    begin_wait(0, 2);
    cfg = 7'h7f;
    ticks(1);
    chk("R9", "busy after first tick", busy, 1'b1);
    ticks(1);
    chk("R9", "old limit still applies", err, 1'b1);
    clear_err();
  endtask

  task automatic t_idle;
    cfg = {3'd0, 4'd1};
    for (int i = 0; i < 5; i++) cyc(0, i[0], 1, 0);
    chk("R10", "idle busy", busy, 1'b0);
    chk("R10", "idle err", err, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_factor(0, 15, 15);
    t_factor(1, 5, 80);
    t_factor(2, 1, 128);
    t_factor(3, 3, 768);
    t_factor(4, 2, 2048);
    t_factor(5, 1, 4096);
    t_factor(6, 1, 65536);
    t_code7();
    t_zero();
    t_gaps();
    t_event();
    t_restart();
    t_sticky();
    t_cfg_change();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule